// File: doc/BRIEF.md
# Doorbell Descriptor Ring Tracker

This block keeps the device-side pointers for one descriptor ring whose depth is a power of two. The host posts work by writing a new producer count to a 32-bit doorbell. The block then issues the ring slots between the consumer count and that producer count, one at a time and in order, over a valid/ready interface. Each accepted slot moves a 32-bit consumer counter forward by one, and the host can read that counter back at any time.

Both counters run freely through the whole 32-bit range and wrap from all-ones to zero. They are not reduced to ring indices. The number of outstanding descriptors is the modular difference of the two counters, and the ring slot is the low bits of the consumer counter. A receive ring also has a data-buffer ring of the same length that moves in step with it, so the block gives the matching data slot alongside each descriptor slot.

Doorbell and readback words are big-endian on the bus, so the block reverses their byte order. A doorbell that would run the ring past its depth, or move the producer backwards, is rejected and flagged.

Top module: `dbr_ring_tracker`

## Requirements
- R1: During and just after reset, both counters hold the parameter CNT_INIT. This gives slot_valid low, pending_cnt zero, db_err low and tail_rd_data equal to the byte-reversed CNT_INIT.
- R2: When BIG_ENDIAN is set, the doorbell value is db_wr_data with its bytes reversed (bus bits 7:0 are counter bits 31:24). An accepted write takes effect on the clock edge that samples it. The producer counter changes through no other path.
- R3: pending_cnt equals (producer − consumer) mod 2^32. It never exceeds RING_DEPTH, and it may reach RING_DEPTH exactly.
- R4: slot_valid is high exactly when pending_cnt is nonzero. slot_idx is the consumer counter's low log2(RING_DEPTH) bits.
- R5: Each cycle with slot_valid and slot_ready both high adds one to the consumer counter at that edge. All other cycles leave the consumer counter unchanged, so slots are issued strictly in order.
- R6: tail_rd_data is the consumer counter with its bytes reversed (counter bits 7:0 appear on bus bits 31:24).
- R7: Both counters wrap from 0xFFFFFFFF to 0x00000000. Slot issue and pending counting carry on across the wrap without a break.
- R8: A doorbell is rejected if it would make pending greater than RING_DEPTH, or if it lies behind the current producer (new − producer mod 2^32 greater than RING_DEPTH). A rejected doorbell leaves the producer unchanged and raises db_err for exactly the following cycle.
- R9: With RX_RING set, data_slot_idx equals slot_idx in every cycle.
- R10: A doorbell equal to the current producer count is accepted without error and changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| db_wr_en | input | 1 | Doorbell write strobe |
| db_wr_data | input | CNT_W | Doorbell value in bus byte order |
| slot_valid | output | 1 | A descriptor slot is ready for the consumer |
| slot_ready | input | 1 | Consumer takes the offered slot |
| slot_idx | output | log2(RING_DEPTH) | Descriptor ring slot on offer |
| data_slot_idx | output | log2(RING_DEPTH) | Matching data-buffer slot (receive rings) |
| pending_cnt | output | log2(RING_DEPTH)+1 | Outstanding descriptors |
| tail_rd_data | output | CNT_W | Consumer counter in bus byte order |
| db_err | output | 1 | One-cycle flag for a rejected doorbell |

## Verification
The bench builds the block with RING_DEPTH of 8, RX_RING set and CNT_INIT of 0xFFFFFFF4. Starting twelve counts below the wrap puts the 32-bit rollover of both counters within a few dozen cycles. The shallow ring makes the full-ring and depth-plus-one doorbell boundaries cheap to hit repeatedly while the slot index cycles many times.

// File: rtl/dbr_pkg.sv
// Package: shared types for the doorbell ring tracker.
// Holds the verdict that the doorbell checker gives for each host write.
package dbr_pkg;

    typedef enum logic [1:0] {
        DB_IDLE    = 2'd0,  // no write this cycle
        DB_ACCEPT  = 2'd1,  // write moves head within bounds
        DB_OVERRUN = 2'd2,  // write would exceed ring depth
        DB_REWIND  = 2'd3   // write lies behind the current head
    } db_verdict_e;

endpackage

// File: rtl/dbr_byte_order.sv
// Module: dbr_byte_order
// Reverses the byte order of a word when SWAP is set, and passes it
// through unchanged otherwise.
// Assumes: W is a multiple of 8.
module dbr_byte_order #(
    parameter int W    = 32,
    parameter bit SWAP = 1'b1
) (
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    localparam int NBYTES = W / 8;

    generate
        if (SWAP) begin : g_swap
            for (genvar b = 0; b < NBYTES; b++) begin : g_byte
                // Move byte b to mirrored position.
                assign dout[8*b +: 8] = din[W-8*(b+1) +: 8];
            end
        end else begin : g_pass
            // Same byte order on both sides.
            assign dout = din;
        end
    endgenerate
endmodule

// File: rtl/dbr_head_ctrl.sv
// Module: dbr_head_ctrl
// Holds the free-running producer counter. Checks each doorbell write
// against the consumer counter and the current head, accepts writes that
// keep occupancy within the ring depth, and flags the rest for one cycle.
// Assumes: wr_head is already in native bit order; DEPTH fits in CNT_W bits.
module dbr_head_ctrl
    import dbr_pkg::*;
#(
    parameter int             CNT_W    = 32,
    parameter int             DEPTH    = 16,
    parameter logic [CNT_W-1:0] CNT_INIT = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [CNT_W-1:0] wr_head,
    input  logic [CNT_W-1:0] tail_cnt,
    output logic [CNT_W-1:0] head_cnt,
    output logic             err
);
    localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);

    logic [CNT_W-1:0] head_q;
    logic [CNT_W-1:0] occ_new;
    logic [CNT_W-1:0] adv_new;
    logic             err_q;
    db_verdict_e      verdict;

    // Classify the incoming doorbell against both counters.
    always_comb begin
        occ_new = wr_head - tail_cnt;
        adv_new = wr_head - head_q;
        if (!wr_en)
            verdict = DB_IDLE;
        else if (adv_new > DEPTH_C)
            verdict = DB_REWIND;
        else if (occ_new > DEPTH_C)
            verdict = DB_OVERRUN;
        else
            verdict = DB_ACCEPT;
    end

    // Register the producer counter and the one-cycle error flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head_q <= CNT_INIT;
            err_q  <= 1'b0;
        end else begin
            err_q <= (verdict == DB_OVERRUN) || (verdict == DB_REWIND);
            if (verdict == DB_ACCEPT)
                head_q <= wr_head;
        end
    end

    assign head_cnt = head_q;
    assign err      = err_q;
endmodule

// File: rtl/dbr_tail_ctrl.sv
// Module: dbr_tail_ctrl
// Holds the free-running consumer counter. Offers the slot at its low bits
// whenever the producer is ahead, and steps by one per accepted slot.
// Assumes: DEPTH is a power of two; head never leads tail by more than DEPTH.
module dbr_tail_ctrl #(
    parameter int             CNT_W    = 32,
    parameter int             DEPTH    = 16,
    parameter logic [CNT_W-1:0] CNT_INIT = '0
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [CNT_W-1:0]         head_cnt,
    input  logic                     take,
    output logic                     avail,
    output logic [$clog2(DEPTH)-1:0] slot,
    output logic [$clog2(DEPTH):0]   pending,
    output logic [CNT_W-1:0]         tail_cnt
);
    localparam int IDX_W = $clog2(DEPTH);

    logic [CNT_W-1:0] tail_q;
    logic [CNT_W-1:0] diff;

    // Occupancy is the modular distance from tail to head.
    always_comb begin
        diff    = head_cnt - tail_q;
        avail   = (diff != '0);
        pending = diff[IDX_W:0];
        slot    = tail_q[IDX_W-1:0];
    end

    // Advance the consumer counter on each accepted slot.
    always_ff @(posedge clk) begin
        if (!rst_n)
            tail_q <= CNT_INIT;
        else if (avail && take)
            tail_q <= tail_q + 1'b1;
    end

    assign tail_cnt = tail_q;
endmodule

// File: rtl/dbr_ring_tracker.sv
// Module: dbr_ring_tracker (top)
// Producer/consumer pointer tracker for one power-of-two descriptor ring.
// Converts the doorbell and the readback to bus byte order, validates the
// doorbell, issues slots in order, and gives the paired data-ring slot
// for receive rings.
// Assumes: RING_DEPTH is a power of two, at least 2; CNT_W is a multiple of 8.
module dbr_ring_tracker #(
    parameter int             RING_DEPTH = 16,
    parameter int             CNT_W      = 32,
    parameter logic [CNT_W-1:0] CNT_INIT   = '0,
    parameter bit             BIG_ENDIAN = 1'b1,
    parameter bit             RX_RING    = 1'b1
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          db_wr_en,
    input  logic [CNT_W-1:0]              db_wr_data,
    output logic                          slot_valid,
    input  logic                          slot_ready,
    output logic [$clog2(RING_DEPTH)-1:0] slot_idx,
    output logic [$clog2(RING_DEPTH)-1:0] data_slot_idx,
    output logic [$clog2(RING_DEPTH):0]   pending_cnt,
    output logic [CNT_W-1:0]              tail_rd_data,
    output logic                          db_err
);
    localparam int IDX_W = $clog2(RING_DEPTH);

    logic [CNT_W-1:0] db_native;
    logic [CNT_W-1:0] head_cnt;
    logic [CNT_W-1:0] tail_cnt;

    // Doorbell from bus order into native order.
    dbr_byte_order #(.W(CNT_W), .SWAP(BIG_ENDIAN)) u_db_order (
        .din  (db_wr_data),
        .dout (db_native)
    );

    // Producer side.
    dbr_head_ctrl #(.CNT_W(CNT_W), .DEPTH(RING_DEPTH), .CNT_INIT(CNT_INIT)) u_head (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (db_wr_en),
        .wr_head  (db_native),
        .tail_cnt (tail_cnt),
        .head_cnt (head_cnt),
        .err      (db_err)
    );

    // Consumer side.
    dbr_tail_ctrl #(.CNT_W(CNT_W), .DEPTH(RING_DEPTH), .CNT_INIT(CNT_INIT)) u_tail (
        .clk      (clk),
        .rst_n    (rst_n),
        .head_cnt (head_cnt),
        .take     (slot_ready),
        .avail    (slot_valid),
        .slot     (slot_idx),
        .pending  (pending_cnt),
        .tail_cnt (tail_cnt)
    );

    // Consumer counter from native order into bus order.
    dbr_byte_order #(.W(CNT_W), .SWAP(BIG_ENDIAN)) u_tail_order (
        .din  (tail_cnt),
        .dout (tail_rd_data)
    );

    generate
        if (RX_RING) begin : g_rx
            // Data ring has the same length and moves with the descriptor ring.
            assign data_slot_idx = slot_idx;
        end else begin : g_tx
            // Transmit rings have no paired data ring.
            assign data_slot_idx = '0;
        end
    endgenerate
endmodule

// File: rtl/dbr_ring_tracker_chk.sv
// Module: dbr_ring_tracker_chk
// Temporal checks on the ring tracker, attached by bind below.
module dbr_ring_tracker_chk #(
    parameter int RING_DEPTH = 16,
    parameter int CNT_W      = 32
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        db_wr_en,
    input logic                        slot_valid,
    input logic                        slot_ready,
    input logic                        db_err,
    input logic [$clog2(RING_DEPTH):0] pending_cnt,
    input logic [CNT_W-1:0]            head_cnt,
    input logic [CNT_W-1:0]            tail_cnt
);
    AST_PENDING_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        pending_cnt <= ($clog2(RING_DEPTH)+1)'(RING_DEPTH)); // R3

    AST_TAIL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_valid && slot_ready) |=> tail_cnt == CNT_W'($past(tail_cnt) + 1'b1)); // R5

    AST_TAIL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(slot_valid && slot_ready) |=> $stable(tail_cnt)); // R5

    AST_HEAD_DOORBELL_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        !db_wr_en |=> $stable(head_cnt)); // R2

    AST_REJECT_KEEPS_HEAD: assert property (@(posedge clk) disable iff (!rst_n)
        db_err |-> head_cnt == $past(head_cnt)); // R8
endmodule

bind dbr_ring_tracker dbr_ring_tracker_chk #(
    .RING_DEPTH (RING_DEPTH),
    .CNT_W      (CNT_W)
) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .db_wr_en    (db_wr_en),
    .slot_valid  (slot_valid),
    .slot_ready  (slot_ready),
    .db_err      (db_err),
    .pending_cnt (pending_cnt),
    .head_cnt    (head_cnt),
    .tail_cnt    (tail_cnt)
);

// File: tb/dbr_ring_tracker_tb_top.sv
// Bench: behavioural model of both counters, compared on every cycle.
module dbr_ring_tracker_tb_top;
    localparam int          DEPTH = 8;
    localparam int          IW    = 3;
    localparam logic [31:0] INIT  = 32'hFFFF_FFF4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        db_wr_en = 1'b0;
    logic [31:0] db_wr_data = '0;
    logic        slot_ready = 1'b0;
    logic        slot_valid;
    logic [IW-1:0] slot_idx;
    logic [IW-1:0] data_slot_idx;
    logic [IW:0]   pending_cnt;
    logic [31:0] tail_rd_data;
    logic        db_err;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    int consumed = 0;

    logic [31:0] m_head;
    logic [31:0] m_tail;
    logic        m_err;

    always #5 clk = ~clk;

    dbr_ring_tracker #(
        .RING_DEPTH (DEPTH),
        .CNT_W      (32),
        .CNT_INIT   (INIT),
        .BIG_ENDIAN (1'b1),
        .RX_RING    (1'b1)
    ) dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .db_wr_en      (db_wr_en),
        .db_wr_data    (db_wr_data),
        .slot_valid    (slot_valid),
        .slot_ready    (slot_ready),
        .slot_idx      (slot_idx),
        .data_slot_idx (data_slot_idx),
        .pending_cnt   (pending_cnt),
        .tail_rd_data  (tail_rd_data),
        .db_err        (db_err)
    );

    function automatic logic [31:0] bswap(input logic [31:0] v);
        return {v[7:0], v[15:8], v[23:16], v[31:24]};
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Compare every output with the model state.
    task automatic compare_all();
        logic [31:0] occ;
        occ = m_head - m_tail;
        chk("R4", "slot_valid", {31'b0, slot_valid}, {31'b0, occ != 0});
        chk("R4", "slot_idx", 32'(slot_idx), 32'(m_tail[IW-1:0]));
        chk("R9", "data_slot_idx", 32'(data_slot_idx), 32'(m_tail[IW-1:0]));
        chk("R3", "pending_cnt", 32'(pending_cnt), occ);
        chk("R6", "tail_rd_data", tail_rd_data, bswap(m_tail));
        chk("R8", "db_err", {31'b0, db_err}, {31'b0, m_err});
    endtask

    // One cycle: check, drive, advance the model to the next edge.
    task automatic step(input bit en, input logic [31:0] hv, input bit rdy);
        logic [31:0] nh;
        logic [31:0] nt;
        logic        ne;
        compare_all();
        db_wr_en   = en;
        db_wr_data = bswap(hv);
        slot_ready = rdy;
        nh = m_head;
        nt = m_tail;
        ne = 1'b0;
        if ((m_head != m_tail) && rdy) begin
            nt = m_tail + 1;
            consumed++;
        end
        if (en) begin
            if ((hv - m_head) > DEPTH || (hv - m_tail) > DEPTH)
                ne = 1'b1;
            else
                nh = hv;
        end
        m_head = nh;
        m_tail = nt;
        m_err  = ne;
        @(negedge clk);
    endtask

    // Consume with a mixed ready pattern until the model ring is empty.
    task automatic drain();
        for (int i = 0; i < 64 && m_head != m_tail; i++)
            step(1'b0, 32'h0, (i % 3) != 2);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL R5 watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        m_head = INIT;
        m_tail = INIT;
        m_err  = 1'b0;
        repeat (3) @(negedge clk);
        // R1: state held in reset
        chk("R1", "valid in reset", {31'b0, slot_valid}, 32'h0);
        chk("R1", "tail in reset", tail_rd_data, bswap(INIT));
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "pending after reset", 32'(pending_cnt), 32'h0);
        chk("R1", "err after reset", {31'b0, db_err}, 32'h0);

        // R2: doorbell of five, nothing taken yet
        step(1'b1, INIT + 5, 1'b0);
        step(1'b0, 32'h0, 1'b0);
        chk("R2", "pending after doorbell", 32'(pending_cnt), 32'd5);
        // R5: take three in order
        for (int i = 0; i < 3; i++) step(1'b0, 32'h0, 1'b1);
        // R10: same head again, while consuming
        step(1'b1, m_head, 1'b1);
        step(1'b0, 32'h0, 1'b0);
        chk("R10", "no error on equal head", {31'b0, db_err}, 32'h0);

        // R8: overrun by one beyond depth
        step(1'b1, m_tail + DEPTH + 1, 1'b0);
        step(1'b0, 32'h0, 1'b0);
        step(1'b0, 32'h0, 1'b0);
        // R8: rewind by one
        step(1'b1, m_head - 1, 1'b0);
        step(1'b0, 32'h0, 1'b0);
        step(1'b0, 32'h0, 1'b0);
        drain();

        // R3: exactly full ring, crossing the counter wrap
        step(1'b1, m_tail + DEPTH, 1'b0);
        step(1'b0, 32'h0, 1'b0);
        chk("R3", "full ring pending", 32'(pending_cnt), DEPTH);
        drain();
        // R7: refill several times through zero
        for (int k = 0; k < 4; k++) begin
            step(1'b1, m_tail + 7, 1'b1);
            drain();
        end
        step(1'b0, 32'h0, 1'b0);
        chk("R7", "tail after wrap", bswap(tail_rd_data), INIT + 32'(consumed));
        chk("R7", "counter wrapped", {31'b0, bswap(tail_rd_data) < INIT}, 32'h1);

        // R8: doorbell while busy, overrun relative to tail
        step(1'b1, m_tail + 3, 1'b0);
        step(1'b1, m_tail + 12, 1'b1);
        step(1'b0, 32'h0, 1'b1);
        drain();
        step(1'b0, 32'h0, 1'b0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule